// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block gathers the completion and fault pulses of one DMA channel pair into a sticky status word. Software reads that word, acknowledges bits through a write-one-to-clear register, and chooses through an enable mask which bits may raise the interrupt. A small mode register picks how the interrupt is delivered. The block drives the wired interrupt line only when wired delivery is chosen. For any other mode it only presents the selected code on `mode_sel`, and a separate message engine acts on it.

Six single-cycle source pulses come in on `src_pulse`. Each one sets a fixed bit of a sparse 32-bit status map. The register port is a simple synchronous write with a combinational read, and it is addressed by byte offset. The interrupt stays pending as long as any bit of status AND enable is set.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset, the status, enable and mode registers read 0 and `irq_line` is low.
- R2: Each source sets one status bit. `src_pulse[0]` sets bit 0 (end of block) and `src_pulse[1]` sets bit 1 (event write-response error). `src_pulse[2]` sets bit 9 (descriptor read-response error), `src_pulse[3]` sets bit 10 (data read error), `src_pulse[4]` sets bit 11 (data write error) and `src_pulse[5]` sets bit 14 (invalid descriptor). A bit becomes visible on read in the cycle after its pulse.
- R3: A status bit stays set until it is cleared. More pulses, and writes to other registers, do not change it.
- R4: Writing a word to the clear register at offset 0x108 clears every status bit where that word holds a 1. Bits where the word holds 0 are left as they are. The clear register reads as 0.
- R5: If a source pulse and a clear of the same bit land in the same cycle, the bit is left set.
- R6: Only bits 0, 1, 9, 10, 11 and 14 exist (mask 0x4E03). All other bits of status and enable read as 0 and cannot be set, even by writing all ones.
- R7: `irq_line` is high exactly when the mode is 1 (wired) and (status AND enable) is nonzero. The line follows register changes in the same cycle they become visible.
- R8: The mode register at offset 0x004 holds the low 4 bits of a write. It reads back in bits 3:0 with all other bits 0, and its value appears on `mode_sel`.
- R9: The status register is at offset 0x100 and ignores writes. The enable register is at offset 0x110. Any other offset reads as 0.
- R10: The enable mask only gates the interrupt. Masked sources still latch into status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| src_pulse | input | 6 | Single-cycle event and error pulses, index order per R2 |
| irq_line | output | 1 | Wired interrupt request |
| mode_sel | output | 4 | Selected delivery mode |

## Verification
The hardest case to reach is a source pulse and a write-one clear of the same bit landing on the same clock edge, since the pulse and the write come from unrelated ports. The bench reaches it by driving both in one low phase, for every source in turn, and reading status afterwards. Two full sweeps cover the rest. One crosses all 64 status subsets with all 64 enable subsets and checks the interrupt against a mask product computed in the bench. The other runs every mode code with all causes pending.

// File: rtl/dma_irq_pkg.sv
// Shared constants for the DMA interrupt status unit.
// Assumes a 32-bit register word and byte offsets on a 12-bit address.
package dma_irq_pkg;
    localparam int NUM_SRC  = 6;
    localparam int REG_W    = 32;
    localparam int OFS_W    = 12;
    localparam int MODE_BITS = 4;

    localparam logic [OFS_W-1:0] OFS_MODE   = 12'h004;
    localparam logic [OFS_W-1:0] OFS_STATUS = 12'h100;
    localparam logic [OFS_W-1:0] OFS_CLEAR  = 12'h108;
    localparam logic [OFS_W-1:0] OFS_ENABLE = 12'h110;

    localparam logic [MODE_BITS-1:0] MODE_WIRED = 4'd1;

    // Status bit position of each source index; the positions are the register layout.
    function automatic int src_bit(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 9;
            3:       return 10;
            4:       return 11;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/irq_status_bank.sv
// Sticky status bits, one per source, kept in compact source order.
// Assumes src_pulse lasts one cycle per event and clr_hit is already decoded
// from a clear-register write. A pulse wins over a clear in the same cycle.
module irq_status_bank #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic [NUM_SRC-1:0] clr_hit,
    output logic [NUM_SRC-1:0] status_q
);
    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_bit
            // Set on pulse, hold otherwise, drop only on a clear with no pulse.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    status_q[i] <= 1'b0;
                else
                    status_q[i] <= src_pulse[i] | (status_q[i] & ~clr_hit[i]);
            end

            assert_pulse_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
                src_pulse[i] |=> status_q[i]);
            assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (status_q[i] && !clr_hit[i]) |=> status_q[i]);
            assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_hit[i] && !src_pulse[i]) |=> !status_q[i]);
        end
    endgenerate
endmodule

// File: rtl/irq_ctrl_regs.sv
// Enable mask (compact source order) and delivery-mode register.
// Assumes the write strobes are already decoded from the offset.
module irq_ctrl_regs #(
    parameter int NUM_SRC   = 6,
    parameter int MODE_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_wr,
    input  logic [NUM_SRC-1:0]   en_data,
    input  logic                 mode_wr,
    input  logic [MODE_BITS-1:0] mode_data,
    output logic [NUM_SRC-1:0]   en_q,
    output logic [MODE_BITS-1:0] mode_q
);
    // Enable mask register: replaced whole on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_wr)
            en_q <= en_data;
    end

    // Mode register: keeps only the mode field of a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (mode_wr)
            mode_q <= mode_data;
    end

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_q));
    assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en_q));
endmodule

// File: rtl/irq_read_mux.sv
// Read-data selection. Expands the compact status and enable vectors onto
// the sparse bit map, so that unimplemented bits are constant zero.
module irq_read_mux #(
    parameter int NUM_SRC   = 6,
    parameter int OFS_W     = 12,
    parameter int REG_W     = 32,
    parameter int MODE_BITS = 4
) (
    input  logic [OFS_W-1:0]     addr,
    input  logic [NUM_SRC-1:0]   status,
    input  logic [NUM_SRC-1:0]   enable,
    input  logic [MODE_BITS-1:0] mode,
    output logic [REG_W-1:0]     rdata
);
    import dma_irq_pkg::*;

    logic [REG_W-1:0] status_word;
    logic [REG_W-1:0] enable_word;
    logic [REG_W-1:0] status_sparse [NUM_SRC];
    logic [REG_W-1:0] enable_sparse [NUM_SRC];

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_map
            localparam int POS = src_bit(i);
            assign status_sparse[i] = REG_W'(status[i]) << POS;
            assign enable_sparse[i] = REG_W'(enable[i]) << POS;
        end
    endgenerate

    // OR the per-source words into the two register images.
    always_comb begin
        status_word = '0;
        enable_word = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            status_word = status_word | status_sparse[k];
            enable_word = enable_word | enable_sparse[k];
        end
    end

    // Offset decode for reads; clear and unknown offsets return zero.
    always_comb begin
        case (addr)
            OFS_STATUS: rdata = status_word;
            OFS_ENABLE: rdata = enable_word;
            OFS_MODE:   rdata = REG_W'(mode);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_irq_unit.sv
// Top of the DMA interrupt status unit: write decode, sticky status,
// enable/mode registers, read mux and the wired interrupt line.
// Assumes single-cycle source pulses and one register access per cycle.
module dma_irq_unit #(
    parameter int OFS_W = dma_irq_pkg::OFS_W,
    parameter int REG_W = dma_irq_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [5:0]       src_pulse,
    output logic             irq_line,
    output logic [3:0]       mode_sel
);
    import dma_irq_pkg::*;

    localparam int NSRC = NUM_SRC;
    localparam int MW   = MODE_BITS;

    logic            wr_clear, wr_enable, wr_mode;
    logic [NSRC-1:0] wdata_src;
    logic [NSRC-1:0] clr_hit;
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] en_q;
    logic [MW-1:0]   mode_q;
    logic [NSRC-1:0] cause;
    logic            unused_wdata;

    // Offset decode of the write strobe.
    always_comb begin
        wr_clear  = reg_wr_en && (reg_addr == OFS_CLEAR);
        wr_enable = reg_wr_en && (reg_addr == OFS_ENABLE);
        wr_mode   = reg_wr_en && (reg_addr == OFS_MODE);
    end

    genvar i;
    generate
        for (i = 0; i < NSRC; i++) begin : g_pick
            localparam int POS = src_bit(i);
            assign wdata_src[i] = reg_wdata[POS];
        end
    endgenerate

    assign unused_wdata = ^reg_wdata;
    assign clr_hit      = wr_clear ? wdata_src : '0;

    irq_status_bank #(.NUM_SRC(NSRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_pulse(src_pulse),
        .clr_hit  (clr_hit),
        .status_q (status_q)
    );

    irq_ctrl_regs #(.NUM_SRC(NSRC), .MODE_BITS(MW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (wr_enable),
        .en_data  (wdata_src),
        .mode_wr  (wr_mode),
        .mode_data(reg_wdata[MW-1:0]),
        .en_q     (en_q),
        .mode_q   (mode_q)
    );

    irq_read_mux #(.NUM_SRC(NSRC), .OFS_W(OFS_W), .REG_W(REG_W), .MODE_BITS(MW)) u_rmux (
        .addr  (reg_addr),
        .status(status_q),
        .enable(en_q),
        .mode  (mode_q),
        .rdata (reg_rdata)
    );

    // Effective cause and wired line gating.
    always_comb begin
        cause    = status_q & en_q;
        irq_line = (mode_q == MODE_WIRED) && (|cause);
        mode_sel = mode_q;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !irq_line);
    assert_status_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == OFS_STATUS && src_pulse == '0) |=> (status_q == $past(status_q)));
endmodule

// File: tb/dma_irq_unit_test.sv
module dma_irq_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  src_pulse = '0;
    logic        irq_line;
    logic [3:0]  mode_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    localparam logic [11:0] A_MODE = 12'h004, A_STAT = 12'h100, A_CLR = 12'h108, A_EN = 12'h110;

    always #5 clk = ~clk;

    dma_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_pulse(src_pulse),
        .irq_line(irq_line), .mode_sel(mode_sel)
    );

    function automatic logic [31:0] spread(input logic [5:0] s);
        int pos [6] = '{0, 1, 9, 10, 11, 14};
        logic [31:0] w = '0;
        for (int k = 0; k < 6; k++) if (s[k]) w[pos[k]] = 1'b1;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] s);
        @(negedge clk);
        src_pulse = s;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_EN, v);   check("R1 enable", v, 0);
        rd(A_MODE, v); check("R1 mode", v, 0);
        check("R1 irq", {31'b0, irq_line}, 0);

        // R9 offsets, R6 unused bits, R8 mode field
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, v);  check("R6 enable mask", v, 32'h0000_4E03);
        rd(A_CLR, v); check("R4 clear reads zero", v, 0);
        rd(12'h200, v); check("R9 unknown offset", v, 0);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); check("R9 status write ignored", v, 0);
        wr(A_EN, 0);

        // R2 single-source map, R10 latch while masked
        for (int k = 0; k < 6; k++) begin
            pulse(6'(1 << k));
            rd(A_STAT, v); check("R2 source bit", v, spread(6'(1 << k)));
            check("R10 masked no irq", {31'b0, irq_line}, 0);
            wr(A_CLR, 32'hFFFF_FFFF);
        end

        // R7 sweep: all status subsets x all enable subsets in wired mode
        wr(A_MODE, 32'h1);
        for (int s = 0; s < 64; s++) begin
            wr(A_CLR, 32'hFFFF_FFFF);
            wr(A_EN, 0);
            pulse(6'(s));
            rd(A_STAT, v); check("R2 subset status", v, spread(6'(s)));
            for (int e = 0; e < 64; e++) begin
                wr(A_EN, spread(6'(e)));
                rd(A_STAT, v);
                check("R7 irq wired", {31'b0, irq_line}, {31'b0, |(6'(s) & 6'(e))});
            end
            check("R3 sticky across writes", v, spread(6'(s)));
        end

        // R8 mode sweep with all causes pending
        wr(A_CLR, 32'hFFFF_FFFF);
        pulse(6'h3F);
        wr(A_EN, 32'hFFFF_FFFF);
        for (int m = 0; m < 16; m++) begin
            wr(A_MODE, 32'hFFFF_FFF0 | 32'(m));
            rd(A_MODE, v); check("R8 mode readback", v, 32'(m));
            check("R8 mode_sel", {28'b0, mode_sel}, 32'(m));
            check("R7 irq by mode", {31'b0, irq_line}, {31'b0, m == 1});
        end
        wr(A_MODE, 32'h1);

        // R4 write of zero no effect, single-bit clears
        wr(A_CLR, 0);
        rd(A_STAT, v); check("R4 zero clear", v, 32'h4E03);
        for (int k = 0; k < 6; k++) begin
            wr(A_CLR, spread(6'(1 << k)));
            rd(A_STAT, v); check("R4 single clear", v, spread(~6'((1 << (k + 1)) - 1)));
        end
        check("R7 irq drops when clear", {31'b0, irq_line}, 0);

        // R3 repeat pulse keeps set
        pulse(6'h01); pulse(6'h01);
        rd(A_STAT, v); check("R3 repeat pulse", v, 32'h1);
        wr(A_CLR, 32'hFFFF_FFFF);

        // R5 pulse and clear of same bit in one cycle
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            src_pulse = 6'(1 << k);
            reg_wr_en = 1'b1; reg_addr = A_CLR; reg_wdata = 32'hFFFF_FFFF;
            @(negedge clk);
            src_pulse = '0; reg_wr_en = 1'b0;
            rd(A_STAT, v); check("R5 pulse beats clear", v, spread(6'(1 << k)));
            wr(A_CLR, 32'hFFFF_FFFF);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule